// File: doc/BRIEF.md
# Hashed Page Table Group Searcher

This block looks up a translation for one virtual address in a hashed page table held in memory. The caller presents a segment descriptor (segment ID, a 2-bit page-size code and a flag saying whether the 64K page size is implemented), the effective address, a precomputed hash, and the table base and hash mask. The block works out the page shift and the abbreviated page value to compare against. It then walks the eight entries of the primary group and, if needed, the eight entries of the secondary group. Each entry is fetched as two doublewords through a memory read port.

The read port is a pair of valid/ready channels with at most one read in flight. A request (`rd_req_valid`, `rd_req_addr`) stays asserted with a stable address until the memory raises `rd_req_ready`. The response is accepted in the cycle where `rd_rsp_valid` and `rd_rsp_ready` are both high. `rd_rsp_ready` is high only while a request is outstanding, so the memory may hold a response back for any number of cycles. Control (`start`, `busy`, `done`) and the result pins are plain levels.

When the search ends, `done` pulses for one cycle and either `hit` or `miss` is raised. On a hit the entry position, both doublewords and the translated real address are presented. All results stay stable until the next accepted `start`.

Top module: `hpt_group_search`

## Requirements
- R1: The page shift comes from `seg_size`. Code 2'b00 gives 12. Code 2'b01 gives 16 when `cap_64k` is 1 and 24 when it is 0. Codes 2'b10 and 2'b11 give 24.
- R2: An entry is a candidate only if all three of these hold. Doubleword 0 bit 0 (valid) is 1. Bit 1 (secondary) equals the pass, 0 for primary and 1 for secondary. Bits [63:7], zero-extended, equal the compare value {`seg_vsid`, `ea`[27:23]}, where `ea` bit 23 is cleared when the shift is 24.
- R3: A candidate matches only if doubleword 1 agrees with the shift. Shift 12 accepts any value. Shift 16 needs bits [15:12] = 4'b0001. Shift 24 needs bits [19:12] = 0. A candidate that fails this test is skipped, and the walk goes on to the next entry.
- R4: Entry i of a group is at base + ((h & `tbl_mask`) << 7) + 16*i. Its doubleword 1 is at +8. The primary pass uses h = `hash` and the secondary pass uses h = ~`hash`. Entries are probed from 0 up to 7.
- R5: The first matching entry in probe order wins, and no read is issued after it. A hit at entry i of the primary group costs 2*(i+1) reads. A hit at entry i of the secondary group costs 16 + 2*(i+1) reads.
- R6: `real_addr` = (dw1[39:0] & ~m) | (`ea` & m), where m = (1 << shift) - 1.
- R7: If no entry in either group matches, the search ends with `miss`=1 and `hit`=0 after exactly 32 reads.
- R8: The end of a search is marked by `done` high for exactly one cycle. On a hit, `hit_index` = {pass, entry number}, and `hit_dw0` and `hit_dw1` hold the matching entry. All results hold until the next accepted `start`.
- R9: `start` is ignored while `busy` is high. A second `start` during a search does not change its result and does not add a second `done`.
- R10: A pending read request keeps its valid and address stable until it is accepted. The result does not depend on request stalls or on response latency.
- R11: After reset, `busy`, `done`, `hit`, `miss` and `rd_req_valid` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a search (accepted only when idle) |
| seg_size | input | 2 | Segment page-size code |
| cap_64k | input | 1 | 64K page size implemented |
| seg_vsid | input | VSID_W | Virtual segment ID |
| ea | input | EA_W | Effective address |
| hash | input | HASH_W | Primary hash value |
| tbl_base | input | PA_W | Table base address |
| tbl_mask | input | HASH_W | Hash mask selecting the group |
| rd_req_valid | output | 1 | Read request valid |
| rd_req_ready | input | 1 | Memory accepts the request |
| rd_req_addr | output | PA_W | Doubleword read address |
| rd_rsp_valid | input | 1 | Read data valid |
| rd_rsp_ready | output | 1 | Block accepts read data |
| rd_rsp_data | input | DW_W | Read data |
| busy | output | 1 | Search in progress |
| done | output | 1 | One-cycle end-of-search pulse |
| hit | output | 1 | Matching entry found |
| miss | output | 1 | No entry matched |
| hit_index | output | IDX_W+1 | {pass, entry number} of the hit |
| hit_dw0 | output | DW_W | First doubleword of the hit |
| hit_dw1 | output | DW_W | Second doubleword of the hit |
| real_addr | output | PA_W | Translated real address |

## Verification
Every result is due in the one cycle where `done` is high. That cycle comes one clock after the check of the deciding entry, so its timing depends on the number of reads and on memory stalls, not on a fixed count. The bench therefore waits at falling edges for `done` and samples every result there. It checks that `done` has fallen one cycle later, and it compares the number of reads the memory model saw against the count that R5 and R7 predict. A stalled, slower memory is used to show that the result is independent of timing.

// File: rtl/hpt_pkg.sv
package hpt_pkg;
  localparam int AVPN_LO  = 23;  // lowest ea bit kept in the compare value
  localparam int AVPN_POS = 7;   // field position inside doubleword 0
  localparam int SZF_LO   = 12;  // size-hint bits start in doubleword 1
  localparam int ENT_LOG2 = 4;   // bytes per entry, log2
  localparam int DW_BYTES = 8;

  typedef enum logic [1:0] {PG_4K, PG_64K, PG_16M} pg_sz_e;
  typedef enum logic [2:0] {S_IDLE, S_FETCH0, S_FETCH1, S_CHECK, S_DONE} st_e;
endpackage

// File: rtl/hpt_seg_decode.sv
module hpt_seg_decode
  import hpt_pkg::*;
#(
  parameter int VSID_W   = 24,
  parameter int SEG_BITS = 28,
  parameter int PA_W     = 40
)(
  input  logic [1:0]                             seg_size,
  input  logic                                   cap_64k,
  input  logic [VSID_W-1:0]                      vsid,
  input  logic [SEG_BITS-1:AVPN_LO]              ea_hi,
  output pg_sz_e                                 sz,
  output logic [PA_W-1:0]                        mask,
  output logic [VSID_W+SEG_BITS-AVPN_LO-1:0]     cmp
);
  logic [4:0] sh;

  always_comb begin
    unique case (seg_size)
      2'b00:   sz = PG_4K;
      2'b01:   sz = cap_64k ? PG_64K : PG_16M;
      default: sz = PG_16M;
    endcase
    case (sz)
      PG_4K:   sh = 5'd12;
      PG_64K:  sh = 5'd16;
      default: sh = 5'd24;
    endcase
    mask = ~({PA_W{1'b1}} << sh);
  end

  assign cmp = {vsid, ea_hi & ~mask[SEG_BITS-1:AVPN_LO]};
endmodule

// File: rtl/hpt_entry_match.sv
module hpt_entry_match
  import hpt_pkg::*;
#(
  parameter int DW_W   = 64,
  parameter int AVPN_W = 29
)(
  input  logic                       vld_bit,
  input  logic                       sec_bit,
  input  logic [DW_W-AVPN_POS-1:0]   avpn_fld,
  input  logic                       pass,
  input  logic [AVPN_W-1:0]          cmp,
  input  pg_sz_e                     sz,
  input  logic [7:0]                 szf,
  output logic                       match
);
  logic cand, size_ok;

  assign cand = vld_bit && (sec_bit == pass) &&
                (avpn_fld == {{(DW_W-AVPN_POS-AVPN_W){1'b0}}, cmp});

  always_comb begin
    case (sz)
      PG_4K:   size_ok = 1'b1;
      PG_64K:  size_ok = (szf[3:0] == 4'b0001);
      default: size_ok = (szf == 8'h00);
    endcase
  end

  assign match = cand && size_ok;
endmodule

// File: rtl/hpt_addr_gen.sv
module hpt_addr_gen
  import hpt_pkg::*;
#(
  parameter int PA_W   = 40,
  parameter int HASH_W = 16,
  parameter int IDX_W  = 3
)(
  input  logic [PA_W-1:0]   base,
  input  logic [HASH_W-1:0] hash,
  input  logic [HASH_W-1:0] tmask,
  input  logic              pass,
  input  logic [IDX_W-1:0]  idx,
  input  logic              dw_sel,
  output logic [PA_W-1:0]   addr
);
  localparam int GRP_SHIFT = IDX_W + ENT_LOG2;
  logic [HASH_W-1:0] h;

  assign h    = pass ? ~hash : hash;
  assign addr = base + (PA_W'(h & tmask) << GRP_SHIFT) + (PA_W'(idx) << ENT_LOG2)
              + (dw_sel ? PA_W'(DW_BYTES) : '0);
endmodule

// File: rtl/hpt_group_search.sv
module hpt_group_search
  import hpt_pkg::*;
#(
  parameter int VSID_W      = 24,
  parameter int EA_W        = 32,
  parameter int SEG_BITS    = 28,
  parameter int PA_W        = 40,
  parameter int HASH_W      = 16,
  parameter int GRP_ENTRIES = 8,
  parameter int DW_W        = 64
)(
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           start,
  input  logic [1:0]                     seg_size,
  input  logic                           cap_64k,
  input  logic [VSID_W-1:0]              seg_vsid,
  input  logic [EA_W-1:0]                ea,
  input  logic [HASH_W-1:0]              hash,
  input  logic [PA_W-1:0]                tbl_base,
  input  logic [HASH_W-1:0]              tbl_mask,
  output logic                           rd_req_valid,
  input  logic                           rd_req_ready,
  output logic [PA_W-1:0]                rd_req_addr,
  input  logic                           rd_rsp_valid,
  output logic                           rd_rsp_ready,
  input  logic [DW_W-1:0]                rd_rsp_data,
  output logic                           busy,
  output logic                           done,
  output logic                           hit,
  output logic                           miss,
  output logic [$clog2(GRP_ENTRIES):0]   hit_index,
  output logic [DW_W-1:0]                hit_dw0,
  output logic [DW_W-1:0]                hit_dw1,
  output logic [PA_W-1:0]                real_addr
);
  localparam int IDX_W  = $clog2(GRP_ENTRIES);
  localparam int AVPN_W = VSID_W + SEG_BITS - AVPN_LO;
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(GRP_ENTRIES - 1);

  st_e               st;
  logic              pass_q, issued_q, hit_q, miss_q, cap_q;
  logic [IDX_W-1:0]  idx_q;
  logic [1:0]        seg_size_q;
  logic [VSID_W-1:0] vsid_q;
  logic [EA_W-1:0]   ea_q;
  logic [HASH_W-1:0] hash_q, tmask_q;
  logic [PA_W-1:0]   base_q;
  logic [DW_W-1:0]   dw0_q, dw1_q;

  pg_sz_e            sz;
  logic [PA_W-1:0]   pg_mask;
  logic [AVPN_W-1:0] cmp;
  logic              ent_match;

  hpt_seg_decode #(.VSID_W(VSID_W), .SEG_BITS(SEG_BITS), .PA_W(PA_W)) u_dec (
    .seg_size(seg_size_q), .cap_64k(cap_q), .vsid(vsid_q),
    .ea_hi(ea_q[SEG_BITS-1:AVPN_LO]), .sz(sz), .mask(pg_mask), .cmp(cmp));

  hpt_entry_match #(.DW_W(DW_W), .AVPN_W(AVPN_W)) u_match (
    .vld_bit(dw0_q[0]), .sec_bit(dw0_q[1]), .avpn_fld(dw0_q[DW_W-1:AVPN_POS]),
    .pass(pass_q), .cmp(cmp), .sz(sz), .szf(dw1_q[SZF_LO+7:SZF_LO]),
    .match(ent_match));

  hpt_addr_gen #(.PA_W(PA_W), .HASH_W(HASH_W), .IDX_W(IDX_W)) u_addr (
    .base(base_q), .hash(hash_q), .tmask(tmask_q), .pass(pass_q), .idx(idx_q),
    .dw_sel(st == S_FETCH1), .addr(rd_req_addr));

  assign rd_req_valid = ((st == S_FETCH0) || (st == S_FETCH1)) && !issued_q;
  assign rd_rsp_ready = issued_q;
  assign busy         = (st != S_IDLE);
  assign done         = (st == S_DONE);
  assign hit          = hit_q;
  assign miss         = miss_q;
  assign hit_index    = {pass_q, idx_q};
  assign hit_dw0      = dw0_q;
  assign hit_dw1      = dw1_q;
  assign real_addr    = (dw1_q[PA_W-1:0] & ~pg_mask) | (PA_W'(ea_q) & pg_mask);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE;  pass_q <= 1'b0;  issued_q <= 1'b0;
      hit_q <= 1'b0; miss_q <= 1'b0;  idx_q <= '0;
      seg_size_q <= '0; cap_q <= 1'b0; vsid_q <= '0; ea_q <= '0;
      hash_q <= '0;  tmask_q <= '0;   base_q <= '0;
      dw0_q <= '0;   dw1_q <= '0;
    end else begin
      case (st)
        S_IDLE: if (start) begin
          seg_size_q <= seg_size; cap_q <= cap_64k; vsid_q <= seg_vsid;
          ea_q <= ea; hash_q <= hash; tmask_q <= tbl_mask; base_q <= tbl_base;
          pass_q <= 1'b0; idx_q <= '0; hit_q <= 1'b0; miss_q <= 1'b0;
          st <= S_FETCH0;
        end
        S_FETCH0, S_FETCH1: begin
          if (rd_req_valid && rd_req_ready) begin
            issued_q <= 1'b1;
          end else if (issued_q && rd_rsp_valid) begin
            issued_q <= 1'b0;
            if (st == S_FETCH0) begin
              dw0_q <= rd_rsp_data;
              st    <= S_FETCH1;
            end else begin
              dw1_q <= rd_rsp_data;
              st    <= S_CHECK;
            end
          end
        end
        S_CHECK: begin
          if (ent_match) begin
            hit_q <= 1'b1;
            st    <= S_DONE;
          end else if (idx_q == LAST_IDX) begin
            if (!pass_q) begin
              pass_q <= 1'b1;
              idx_q  <= '0;
              st     <= S_FETCH0;
            end else begin
              miss_q <= 1'b1;
              st     <= S_DONE;
            end
          end else begin
            idx_q <= idx_q + 1'b1;
            st    <= S_FETCH0;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R7
  done_outcome_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (hit ^ miss));

  // R2
  hit_cand_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> (hit_dw0[0] && (hit_dw0[1] == hit_index[IDX_W])));

  // R10
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req_valid && !rd_req_ready) |=> (rd_req_valid && $stable(rd_req_addr)));
endmodule

// File: tb/hpt_group_search_bench.sv
module hpt_group_search_bench;
  localparam int CLK_PERIOD = 10;
  localparam logic [39:0] BASE = 40'h00_0001_0000;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [1:0] seg_size = '0;
  logic cap_64k = 1'b0;
  logic [23:0] seg_vsid = '0;
  logic [31:0] ea = '0;
  logic [15:0] hash = '0, tbl_mask = 16'h0003;
  logic [39:0] tbl_base = BASE;
  logic rd_req_valid, rd_req_ready = 1'b1, rd_rsp_valid = 1'b0, rd_rsp_ready;
  logic [39:0] rd_req_addr, real_addr;
  logic [63:0] rd_rsp_data = '0, hit_dw0, hit_dw1;
  logic busy, done, hit, miss;
  logic [3:0] hit_index;

  int tests = 0, fails = 0, reads = 0, bad_addr = 0, lat = 0, cnt = 0;
  bit stall_en = 1'b0, pend = 1'b0;
  logic [7:0] tick = '0;
  logic [63:0] pdata = '0;
  logic [63:0] mem [0:63];

  always #(CLK_PERIOD/2) clk = ~clk;

  hpt_group_search u_hpt_group_search (
    .clk, .rst_n, .start, .seg_size, .cap_64k, .seg_vsid, .ea, .hash,
    .tbl_base, .tbl_mask, .rd_req_valid, .rd_req_ready, .rd_req_addr,
    .rd_rsp_valid, .rd_rsp_ready, .rd_rsp_data, .busy, .done, .hit, .miss,
    .hit_index, .hit_dw0, .hit_dw1, .real_addr);

  // memory model: one read in flight, optional stalls and latency
  always @(posedge clk) begin
    tick <= tick + 1'b1;
    rd_req_ready <= stall_en ? (tick[0] ^ tick[2]) : 1'b1;
    if (rd_rsp_valid && rd_rsp_ready) rd_rsp_valid <= 1'b0;
    if (rd_req_valid && rd_req_ready) begin
      pend  <= 1'b1;
      pdata <= mem[rd_req_addr[8:3]];
      cnt   <= lat;
      reads <= reads + 1;
      if (rd_req_addr[39:9] != BASE[39:9]) bad_addr <= bad_addr + 1;
    end else if (pend && !rd_rsp_valid) begin
      if (cnt == 0) begin
        rd_rsp_valid <= 1'b1;
        rd_rsp_data  <= pdata;
        pend         <= 1'b0;
      end else cnt <= cnt - 1;
    end
  end

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [28:0] cmpv(input logic [23:0] v, input logic [31:0] a, input bit big);
    return {v, a[27:23] & (big ? 5'b11110 : 5'b11111)};
  endfunction
  function automatic logic [63:0] mk0(input bit vld, input bit sec, input logic [28:0] c);
    return {28'b0, c, 5'b0, sec, vld};
  endfunction
  function automatic logic [39:0] ra(input logic [39:0] d1, input logic [31:0] a, input int sh);
    logic [39:0] m = (40'd1 << sh) - 40'd1;
    return (d1 & ~m) | ({8'b0, a} & m);
  endfunction

  task automatic clear_mem();
    for (int i = 0; i < 64; i++) mem[i] = '0;
  endtask
  task automatic put(input int g, input int i, input logic [63:0] d0, input logic [63:0] d1);
    mem[g*16 + i*2]     = d0;
    mem[g*16 + i*2 + 1] = d1;
  endtask

  int r0;
  task automatic run(input logic [1:0] ss, input bit cap, input logic [23:0] v,
                     input logic [31:0] a, input int busy_kick);
    @(negedge clk);
    seg_size = ss; cap_64k = cap; seg_vsid = v; ea = a; hash = 16'hFFF5;
    r0 = reads;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int k = 0; k < 4000 && !done; k++) begin
      if (k == busy_kick) begin seg_vsid = ~v; ea = ~a; start = 1'b1; end
      else start = 1'b0;
      @(negedge clk);
    end
    start = 1'b0;
  endtask

  task automatic expect_hit(input string tag, input logic [3:0] idx, input logic [63:0] d0,
                            input logic [63:0] d1, input logic [39:0] exp_ra, input int nreads);
    chk({tag, " R8 done"}, done, 1);
    chk({tag, " R5 hit"}, {hit, miss}, 2'b10);
    chk({tag, " R8 index"}, hit_index, idx);
    chk({tag, " R8 dw0"}, hit_dw0, d0);
    chk({tag, " R8 dw1"}, hit_dw1, d1);
    chk({tag, " R6 real_addr"}, real_addr, exp_ra);
    chk({tag, " R5 reads"}, reads - r0, nreads);
    @(negedge clk);
    chk({tag, " R8 done pulse"}, done, 0);
  endtask

  logic [23:0] V = 24'hABCDE1;
  logic [31:0] A = 32'h0DA5_4321;  // ea bit 23 is 1

  // primary group = 1, secondary group = (~16'hFFF5) & 3 = 2
  task automatic t_reset();
    chk("R11 busy", busy, 0); chk("R11 done", done, 0);
    chk("R11 hit", hit, 0);   chk("R11 miss", miss, 0);
    chk("R11 req_valid", rd_req_valid, 0);
  endtask

  task automatic setup_4k();
    clear_mem();
    put(1, 0, mk0(0, 0, cmpv(V, A, 0)), 64'h0);
    put(1, 1, mk0(1, 1, cmpv(V, A, 0)), 64'h0);
    put(1, 2, mk0(1, 0, cmpv(V, A, 0) ^ 29'd1), 64'h0);
    put(1, 3, mk0(1, 0, cmpv(V, A, 0)), 64'h12_3456_7ABC);
  endtask

  task automatic t_4k();  // R1 R2 R4
    setup_4k();
    run(2'b00, 0, V, A, -1);
    expect_hit("4k", 4'h3, mk0(1, 0, cmpv(V, A, 0)), 64'h12_3456_7ABC,
               ra(40'h12_3456_7ABC, A, 12), 8);
  endtask

  task automatic t_64k();  // R1 R3
    clear_mem();
    put(1, 0, mk0(1, 0, cmpv(V, A, 0)), 64'h22_2220_0000);
    put(1, 1, mk0(1, 0, cmpv(V, A, 0)), 64'h33_4455_1000);
    run(2'b01, 1, V, A, -1);
    expect_hit("64k", 4'h1, mk0(1, 0, cmpv(V, A, 0)), 64'h33_4455_1000,
               ra(40'h33_4455_1000, A, 16), 4);
  endtask

  task automatic t_64k_nocap();  // R1 R3: 64K code without capability behaves as 16M
    clear_mem();
    put(1, 0, mk0(1, 0, cmpv(V, A, 1)), 64'h44_0000_1000);
    put(1, 1, mk0(1, 0, cmpv(V, A, 0)), 64'h44_0000_0000);
    put(1, 2, mk0(1, 0, cmpv(V, A, 1)), 64'h55_6600_0000);
    run(2'b01, 0, V, A, -1);
    expect_hit("nocap", 4'h2, mk0(1, 0, cmpv(V, A, 1)), 64'h55_6600_0000,
               ra(40'h55_6600_0000, A, 24), 6);
  endtask

  task automatic setup_sec();
    clear_mem();
    put(1, 5, mk0(1, 1, cmpv(V, A, 1)), 64'h66_0000_0000);
    put(2, 0, mk0(1, 0, cmpv(V, A, 1)), 64'h66_0000_0000);
    put(2, 4, mk0(1, 1, cmpv(V, A, 1)), 64'h77_0000_0000);
  endtask

  task automatic t_secondary();  // R4 R5
    setup_sec();
    run(2'b11, 1, V, A, -1);
    expect_hit("sec", 4'hC, mk0(1, 1, cmpv(V, A, 1)), 64'h77_0000_0000,
               ra(40'h77_0000_0000, A, 24), 26);
  endtask

  task automatic t_miss();  // R7
    clear_mem();
    for (int i = 0; i < 8; i++) begin
      put(1, i, mk0(1, 1, cmpv(V, A, 0)), 64'h0);
      put(2, i, mk0(1, 1, cmpv(V, A, 0)), 64'h0);
    end
    run(2'b10, 0, V, A, -1);
    chk("R7 done", done, 1);
    chk("R7 miss", {hit, miss}, 2'b01);
    chk("R7 reads", reads - r0, 32);
  endtask

  task automatic t_busy_start();  // R9 R5 R8
    int seen = 0;
    setup_4k();
    run(2'b00, 0, V, A, 2);
    expect_hit("busy R9", 4'h3, mk0(1, 0, cmpv(V, A, 0)), 64'h12_3456_7ABC,
               ra(40'h12_3456_7ABC, A, 12), 8);
    r0 = reads;
    for (int k = 0; k < 40; k++) begin
      @(negedge clk);
      if (done) seen++;
    end
    chk("R9 no second done", seen, 0);
    chk("R5 no reads after hit", reads - r0, 0);
    chk("R8 hit held", {hit, hit_index}, {1'b1, 4'h3});
  endtask

  task automatic t_stall();  // R10
    stall_en = 1'b1; lat = 3;
    setup_sec();
    run(2'b11, 1, V, A, -1);
    expect_hit("stall R10", 4'hC, mk0(1, 1, cmpv(V, A, 1)), 64'h77_0000_0000,
               ra(40'h77_0000_0000, A, 24), 26);
    stall_en = 1'b0; lat = 0;
  endtask

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog actual=hung expected=finished");
    finish_run();
  end

  initial begin
    clear_mem();
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_4k();
    t_64k();
    t_64k_nocap();
    t_secondary();
    t_miss();
    t_busy_start();
    t_stall();
    chk("R4 address range", bad_addr, 0);
    finish_run();
  end
endmodule